// File: doc/BRIEF.md
# Strict-Priority Iterative Crossbar Matcher

This block schedules an N x N crossbar with several traffic classes. Each input holds one request bit for every pair of class and output, so the switch carries P x N x N request bits. In every cell time the block runs a fixed number of request, grant and accept rounds. All rounds are unrolled within a single clock cycle. The result is a conflict-free match, registered on the next clock edge, together with the class of every connection.

Class P-1 is the most urgent and class 0 the least. At both the grant and the accept step, a port first narrows its candidates to the highest class on offer. Among those candidates, a rotating pointer breaks ties. A low class that keeps meeting a higher one at the same port may wait indefinitely, and this starvation is accepted by design.

One grant pointer per output and one accept pointer per input are shared by all classes. The pointers advance only when an accept happens in the first round, which keeps the output arbiters out of lock-step. A match made in one round stays for the rest of the cell time, and later rounds consider only ports that are still free.

Top module: `xbp_prio_matcher`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `match_o` and `lvl_o` are all zero and every grant and accept pointer is 0.
- R2: The match reported on `match_o`/`lvl_o` is computed from the `req_i` value present before the preceding rising clock edge. A change of `req_i` does not alter the outputs before that edge.
- R3: In `match_o` (bit i*N+o means input i connected to output o), each input row and each output column has at most one bit set.
- R4: The request from input i to output o exists when any bit `req_i[(i*N+o)*P + p]` is set, and its class is the highest such p. Only pairs with a request can be matched.
- R5: A free output that sees requests from free inputs grants only among the requests of the highest class present. It picks the first of these in ascending index order, wrapping, starting at its grant pointer.
- R6: A free input that receives grants accepts only among the grants of the highest class present. It picks the first of these in ascending output order, wrapping, starting at its accept pointer.
- R7: An accept in the first round moves that output's grant pointer to one past the input and that input's accept pointer to one past the output, both modulo N. Accepts in later rounds and unaccepted grants leave the pointers unchanged.
- R8: ITERS rounds run per cell time. A match made in one round is kept, and only inputs and outputs still unmatched take part in later rounds. All rounds use the pointer values from the start of the cell time.
- R9: `lvl_o[i*LW +: LW]` gives the class of the request on which input i was matched, and is zero when input i is unmatched.
- R10: An input whose only request is at a lower class than a persistent competing request to the same output is never matched to that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cell time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N*N*P | Request bits; bit (i*N+o)*P+p is class p from input i to output o |
| match_o | output | N*N | Registered match; bit i*N+o set when input i is connected to output o |
| lvl_o | output | N*LW | Registered class of each input's match, LW bits per input |

## Verification
The bench builds the block with N = 4 ports, P = 4 classes and 2 rounds. With these values, 64 request bits give dense contention. Every class comparison at both grant and accept can be exercised, and second-round matches are reachable. A reference model in the bench tracks its own pointers and predicts every cycle of a long pseudo-random sweep. Directed patterns cover pointer rotation, class preference at each step, second-round fill-in with its frozen pointers, and persistent starvation of a lower class.

// File: rtl/xbp_pkg.sv
package xbp_pkg;

    localparam int unsigned XB_PORTS  = 4;
    localparam int unsigned XB_LEVELS = 4;
    localparam int unsigned XB_ITERS  = 2;

    // width of an index into a set of n items, at least one bit
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // advance a round-robin position by one, modulo n
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/xbp_level_enc.sv
module xbp_level_enc
    import xbp_pkg::*;
#(
    parameter int unsigned N  = XB_PORTS,
    parameter int unsigned P  = XB_LEVELS,
    parameter int unsigned LW = idx_width(P)
) (
    input  logic [N*N*P-1:0]  req_i,
    output logic [N*N-1:0]    has_o,
    output logic [N*N*LW-1:0] lvl_o
);

    for (genvar q = 0; q < N*N; q++) begin : g_pair
        logic [LW-1:0] top;
        always_comb begin
            top = '0;
            for (int p = 0; p < P; p++) begin
                if (req_i[q*P + p]) top = LW'(p);
            end
        end
        assign has_o[q]          = |req_i[q*P +: P];
        assign lvl_o[q*LW +: LW] = top;
    end

endmodule

// File: rtl/xbp_rr_pick.sv
module xbp_rr_pick
    import xbp_pkg::*;
#(
    parameter int unsigned N  = XB_PORTS,
    parameter int unsigned IW = idx_width(N)
) (
    input  logic [N-1:0]  cand_i,
    input  logic [IW-1:0] ptr_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int unsigned k = 0; k < N; k++) begin
            int unsigned pos;
            pos = (int'(ptr_i) + k) % N;
            if (!hit_o && cand_i[pos]) begin
                hit_o = 1'b1;
                idx_o = IW'(pos);
            end
        end
    end

endmodule

// File: rtl/xbp_iter.sv
module xbp_iter
    import xbp_pkg::*;
#(
    parameter int unsigned N  = XB_PORTS,
    parameter int unsigned P  = XB_LEVELS,
    parameter int unsigned IW = idx_width(N),
    parameter int unsigned LW = idx_width(P)
) (
    input  logic [N-1:0]      in_free_i,
    input  logic [N-1:0]      out_free_i,
    input  logic [N*N-1:0]    has_i,
    input  logic [N*N*LW-1:0] lvl_i,
    input  logic [N*IW-1:0]   gptr_i,
    input  logic [N*IW-1:0]   aptr_i,
    output logic [N-1:0]      acc_v_o,
    output logic [N*IW-1:0]   acc_out_o
);

    logic [N-1:0]  g_hit;
    logic [IW-1:0] g_idx [N];

    // grant: each free output narrows to its top class, then rotates
    for (genvar o = 0; o < N; o++) begin : g_grant
        logic [N-1:0]  rq;
        logic [N-1:0]  cand;
        logic [LW-1:0] top;
        always_comb begin
            top = '0;
            for (int i = 0; i < N; i++) begin
                rq[i] = in_free_i[i] && out_free_i[o] && has_i[i*N + o];
                if (rq[i] && (lvl_i[(i*N + o)*LW +: LW] > top))
                    top = lvl_i[(i*N + o)*LW +: LW];
            end
            for (int i = 0; i < N; i++)
                cand[i] = rq[i] && (lvl_i[(i*N + o)*LW +: LW] == top);
        end
        xbp_rr_pick #(.N(N), .IW(IW)) u_pick (
            .cand_i (cand),
            .ptr_i  (gptr_i[o*IW +: IW]),
            .hit_o  (g_hit[o]),
            .idx_o  (g_idx[o])
        );
    end

    // accept: each input narrows its grants to the top class, then rotates
    for (genvar i = 0; i < N; i++) begin : g_accept
        logic [N-1:0]  gv;
        logic [N-1:0]  cand;
        logic [LW-1:0] top;
        logic [IW-1:0] sel;
        always_comb begin
            top = '0;
            for (int o = 0; o < N; o++) begin
                gv[o] = g_hit[o] && (g_idx[o] == IW'(i));
                if (gv[o] && (lvl_i[(i*N + o)*LW +: LW] > top))
                    top = lvl_i[(i*N + o)*LW +: LW];
            end
            for (int o = 0; o < N; o++)
                cand[o] = gv[o] && (lvl_i[(i*N + o)*LW +: LW] == top);
        end
        xbp_rr_pick #(.N(N), .IW(IW)) u_pick (
            .cand_i (cand),
            .ptr_i  (aptr_i[i*IW +: IW]),
            .hit_o  (acc_v_o[i]),
            .idx_o  (sel)
        );
        assign acc_out_o[i*IW +: IW] = sel;
    end

endmodule

// File: rtl/xbp_prio_matcher.sv
module xbp_prio_matcher
    import xbp_pkg::*;
#(
    parameter int unsigned N     = XB_PORTS,
    parameter int unsigned P     = XB_LEVELS,
    parameter int unsigned ITERS = XB_ITERS,
    localparam int unsigned IW   = idx_width(N),
    localparam int unsigned LW   = idx_width(P)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N*N*P-1:0]   req_i,
    output logic [N*N-1:0]     match_o,
    output logic [N*LW-1:0]    lvl_o
);

    logic [N*N-1:0]    has;
    logic [N*N*LW-1:0] lvl_all;
    logic [N*IW-1:0]   gptr_q;
    logic [N*IW-1:0]   aptr_q;
    logic [N*N-1:0]    match_q;
    logic [N*LW-1:0]   lvl_q;
    logic [N*N-1:0]    match_nxt;
    logic [N*LW-1:0]   lvl_nxt;

    logic [N-1:0]      in_free_s  [ITERS+1];
    logic [N-1:0]      out_free_s [ITERS+1];
    logic [N-1:0]      acc_v_s    [ITERS];
    logic [N*IW-1:0]   acc_o_s    [ITERS];

    xbp_level_enc #(.N(N), .P(P), .LW(LW)) u_enc (
        .req_i (req_i),
        .has_o (has),
        .lvl_o (lvl_all)
    );

    assign in_free_s[0]  = '1;
    assign out_free_s[0] = '1;

    for (genvar k = 0; k < ITERS; k++) begin : g_round
        xbp_iter #(.N(N), .P(P), .IW(IW), .LW(LW)) u_iter (
            .in_free_i  (in_free_s[k]),
            .out_free_i (out_free_s[k]),
            .has_i      (has),
            .lvl_i      (lvl_all),
            .gptr_i     (gptr_q),
            .aptr_i     (aptr_q),
            .acc_v_o    (acc_v_s[k]),
            .acc_out_o  (acc_o_s[k])
        );
        assign in_free_s[k+1] = in_free_s[k] & ~acc_v_s[k];
        always_comb begin
            out_free_s[k+1] = out_free_s[k];
            for (int i = 0; i < N; i++) begin
                if (acc_v_s[k][i])
                    out_free_s[k+1][acc_o_s[k][i*IW +: IW]] = 1'b0;
            end
        end
    end

    // merge the matches of all rounds
    always_comb begin
        match_nxt = '0;
        lvl_nxt   = '0;
        for (int k = 0; k < ITERS; k++) begin
            for (int i = 0; i < N; i++) begin
                if (acc_v_s[k][i]) begin
                    match_nxt[i*N + int'(acc_o_s[k][i*IW +: IW])] = 1'b1;
                    lvl_nxt[i*LW +: LW] =
                        lvl_all[(i*N + int'(acc_o_s[k][i*IW +: IW]))*LW +: LW];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            lvl_q   <= '0;
            gptr_q  <= '0;
            aptr_q  <= '0;
        end else begin
            match_q <= match_nxt;
            lvl_q   <= lvl_nxt;
            for (int i = 0; i < N; i++) begin
                if (acc_v_s[0][i]) begin
                    aptr_q[i*IW +: IW] <=
                        IW'(wrap_inc(int'(acc_o_s[0][i*IW +: IW]), N));
                    gptr_q[int'(acc_o_s[0][i*IW +: IW])*IW +: IW] <=
                        IW'(wrap_inc(i, N));
                end
            end
        end
    end

    assign match_o = match_q;
    assign lvl_o   = lvl_q;

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    logic [N-1:0] col_any;
    always_comb begin
        col_any = '0;
        for (int i = 0; i < N; i++) col_any = col_any | match_q[i*N +: N];
    end

    for (genvar i = 0; i < N; i++) begin : g_chk_row
        assert_row_onehot_R3: assert property (@(posedge clk) disable iff (rst)
            $onehot0(match_q[i*N +: N]));
        assert_idle_level_R9: assert property (@(posedge clk) disable iff (rst)
            (match_q[i*N +: N] == '0) |-> (lvl_q[i*LW +: LW] == '0));
        for (genvar o = 0; o < N; o++) begin : g_pair
            // matched class must be the highest class requested one cycle earlier
            assert_top_class_R4: assert property (@(posedge clk) disable iff (rst)
                match_q[i*N + o] |->
                (($past(req_i[(i*N + o)*P +: P]) >> lvl_q[i*LW +: LW]) == P'(1)));
        end
    end

    for (genvar o = 0; o < N; o++) begin : g_chk_col
        logic [N-1:0] col;
        always_comb
            for (int i = 0; i < N; i++) col[i] = match_q[i*N + o];
        assert_col_onehot_R3: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));
        assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (gptr_q[o*IW +: IW] != $past(gptr_q[o*IW +: IW])) |-> col_any[o]);
    end

endmodule

// File: tb/sim_xbp_prio_matcher.sv
module sim_xbp_prio_matcher;

    localparam int N  = 4;
    localparam int P  = 4;
    localparam int IT = 2;
    localparam int LW = 2;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N*N*P-1:0] req = '0;
    logic [N*N-1:0]   match_o;
    logic [N*LW-1:0]  lvl_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int gp [N];
    int ap [N];
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbp_prio_matcher #(.N(N), .P(P), .ITERS(IT)) u0 (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .match_o (match_o),
        .lvl_o   (lvl_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N*N*P-1:0] bitof(input int i, input int o, input int p);
        logic [N*N*P-1:0] v;
        v = '0;
        v[(i*N + o)*P + p] = 1'b1;
        return v;
    endfunction

    // reference model from the requirements, with its own pointers
    task automatic model_step(input logic [N*N*P-1:0] r,
                              output logic [N*N-1:0] m, output logic [N*LW-1:0] l);
        int lv [N][N];
        bit fi [N];
        bit fo [N];
        int gsel [N];
        int ngp [N];
        int nap [N];
        m = '0;
        l = '0;
        for (int i = 0; i < N; i++) begin
            fi[i] = 1; fo[i] = 1; ngp[i] = gp[i]; nap[i] = ap[i];
            for (int o = 0; o < N; o++) begin
                lv[i][o] = -1;
                for (int p = 0; p < P; p++) if (r[(i*N + o)*P + p]) lv[i][o] = p;
            end
        end
        for (int it = 0; it < IT; it++) begin
            for (int o = 0; o < N; o++) begin
                int best;
                best = -1;
                gsel[o] = -1;
                if (fo[o])
                    for (int i = 0; i < N; i++)
                        if (fi[i] && lv[i][o] > best) best = lv[i][o];
                if (best >= 0)
                    for (int k = N - 1; k >= 0; k--) begin
                        int i;
                        i = (gp[o] + k) % N;
                        if (fi[i] && lv[i][o] == best) gsel[o] = i;
                    end
            end
            for (int i = 0; i < N; i++) begin
                int best;
                int pick;
                best = -1;
                pick = -1;
                for (int o = 0; o < N; o++)
                    if (gsel[o] == i && lv[i][o] > best) best = lv[i][o];
                if (best >= 0)
                    for (int k = N - 1; k >= 0; k--) begin
                        int o;
                        o = (ap[i] + k) % N;
                        if (gsel[o] == i && lv[i][o] == best) pick = o;
                    end
                if (pick >= 0) begin
                    fi[i] = 0;
                    fo[pick] = 0;
                    m[i*N + pick] = 1'b1;
                    l[i*LW +: LW] = LW'(lv[i][pick]);
                    if (it == 0) begin
                        ngp[pick] = (i + 1) % N;
                        nap[i] = (pick + 1) % N;
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            gp[i] = ngp[i];
            ap[i] = nap[i];
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 match in reset", match_o, '0);
        chk("R1 level in reset", lvl_o, '0);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin
            gp[i] = 0;
            ap[i] = 0;
        end
    endtask

    task automatic step(input logic [N*N*P-1:0] v, input string tag);
        logic [N*N-1:0]  em;
        logic [N*LW-1:0] el;
        bit ok;
        req = v;
        model_step(v, em, el);
        @(posedge clk);
        #1;
        chk({tag, " match"}, match_o, em);
        chk({tag, " level"}, lvl_o, el);
        ok = 1;
        for (int a = 0; a < N; a++) begin
            int rc;
            int cc;
            rc = 0; cc = 0;
            for (int b = 0; b < N; b++) begin
                rc += match_o[a*N + b];
                cc += match_o[b*N + a];
            end
            if (rc > 1 || cc > 1) ok = 0;
        end
        chk("R3 conflict free", 64'(ok), 64'd1);
    endtask

    initial begin
        do_reset();
        #1;
        chk("R1 after reset", match_o, '0);

        // R4 R9 R2: single class-2 request from input 2 to output 1
        req = bitof(2, 1, 2) | bitof(2, 1, 0);
        #1;
        chk("R2 no change before edge", match_o, '0);
        step(bitof(2, 1, 2) | bitof(2, 1, 0), "R4");
        chk("R4 pair 2-1 matched", match_o, 16'h0200);
        chk("R9 input 2 class 2", lvl_o, 8'h20);

        // R5: output 0 prefers class 3 of input 3 over class 1 of input 0
        step(bitof(0, 0, 1) | bitof(3, 0, 3), "R5");
        chk("R5 higher class granted", match_o, 16'h1000);
        chk("R9 input 3 class 3", lvl_o, 8'hC0);

        // R6: input 0 gets grants from outputs 1 (class 0) and 2 (class 2)
        step(bitof(0, 1, 0) | bitof(0, 2, 2), "R6");
        chk("R6 higher class accepted", match_o, 16'h0004);
        chk("R9 input 0 class 2", lvl_o, 8'h02);

        // R7: tie at one class rotates the grant pointer
        do_reset();
        step(bitof(0, 0, 2) | bitof(1, 0, 2), "R7");
        chk("R7 first winner input 0", match_o, 16'h0001);
        step(bitof(0, 0, 2) | bitof(1, 0, 2), "R7");
        chk("R7 second winner input 1", match_o, 16'h0010);
        step(bitof(0, 0, 2) | bitof(1, 0, 2), "R7");
        chk("R7 third winner input 0", match_o, 16'h0001);

        // R8: second round fills input 1 to output 1
        do_reset();
        step(bitof(0, 0, 3) | bitof(0, 1, 3) | bitof(1, 1, 3), "R8");
        chk("R8 two-round match", match_o, 16'h0021);
        chk("R8 levels", lvl_o, 8'h0F);
        // R7: second-round accept left output 1 pointer at 0
        step(bitof(0, 1, 3) | bitof(2, 1, 3), "R7");
        chk("R7 pointer frozen by later round", match_o, 16'h0002);

        // R10: class 0 of input 1 starves behind class 3 of input 0
        for (int c = 0; c < 8; c++) begin
            step(bitof(0, 0, 3) | bitof(1, 0, 0), "R10");
            chk("R10 input 1 starved", 64'(match_o[7:4]), 64'd0);
            chk("R10 input 0 served", 64'(match_o[3:0]), 64'd1);
        end

        // R5 R6 R8: pseudo-random sweep against the model
        for (int c = 0; c < 3000; c++) begin
            logic [63:0] a;
            logic [63:0] b;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
            a = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
            b = seed;
            if (c % 3 == 0) step(a, "R5/R6/R8 sweep");
            else            step(a & b, "R5/R6/R8 sweep");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule